// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the management register file of a small 10/100 Ethernet PHY, seen at the level of whole register transactions. A MAC-side management unit presents a PHY address, a register address and write data, and issues command strobes: write, read and scan. The block answers only at one fixed PHY address. It holds sixteen 16-bit registers: a control word, a status word, two identity words, an advertisement word, a link-partner ability word and ten general words.

Identity words and most of the status word are fixed. Bit 2 of the status word shows the synchronised link state. The link-partner word gains or loses its ability bits when the link comes up or goes down. Writing the control word with bit 15 set returns every register to its reset value and does not store the written word. A read command captures the addressed word and a link-fail flag. While scan mode is on, the link-fail flag tracks the link without any further command.

Top module: `mgmt_phy_regs`

## Requirements
- R1: After reset the registers read: index 0 = 0x1000, 1 = 0x7848, 2 = 0x2000, 3 = 0x5C90, 4 = 0x01E1, every other index below 16 = 0x0000 (index 5 then follows R10). rdata_o and link_fail_o are 0.
- R2: Index 1 reads 0x7848 with bit 2 equal to the synchronised link state, and ignores writes.
- R3: Indices 2 and 3 always read their identity values and ignore writes.
- R4: Indices 0 and 4 to 15 store the written word (for index 0 only when bit 15 is clear). A write to an index of 16 or more changes nothing, and a read of such an index returns 0.
- R5: A write of index 0 with bit 15 set puts every register back to its R1 value. Index 5 is then 0x01E1 if the link is up and 0 if it is down.
- R6: Only PHY address 1 responds. Writes to any other PHY address are ignored, and a read there returns 0xFFFF.
- R7: A write happens on a command with cmd_i bit 2 set (cmd_valid_i high), or on a data_wr_i pulse. Both use the current PHY and register address.
- R8: A command with cmd_i bit 1 set loads rdata_o on the next edge with the addressed word and sets link_fail_o to the inverted synchronised link. rdata_o holds between reads. When a command carries both bits 1 and 2, the read returns the word held before that write.
- R9: Every command loads scan mode from cmd_i bit 0. While scan mode is on, link_fail_o follows the inverted synchronised link each cycle. While it is off, link changes leave link_fail_o alone.
- R10: When the synchronised link rises, index 5 is ORed with 0x01E1. When it falls, index 5 is ANDed with 0x01FF.
- R11: link_up_i passes through two flops, so a change becomes visible on link_fail_o in scan mode on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register index |
| wdata_i | input | 16 | Write data |
| data_wr_i | input | 1 | Write pulse from the transmit-data path |
| cmd_valid_i | input | 1 | Qualifies cmd_i for one cycle |
| cmd_i | input | 3 | Bit 2 write, bit 1 read, bit 0 scan |
| link_up_i | input | 1 | Asynchronous link state |
| rdata_o | output | 16 | Last read result |
| link_fail_o | output | 1 | Link-fail flag |

## Verification
Every cycle, assertions check that soft reset restores the control word, that a link rise sets the partner ability bits, and that advertisement writes are stored. They also check the 0xFFFF answer for a foreign PHY, the zero answer for an out-of-range index, that rdata_o holds between reads, and that link_fail_o tracks the link in scan mode. The bench scenarios cover the rest: sweeps across all 32 register indices and all 32 PHY addresses, the three-edge link latency, scan being turned off, the two write triggers, and the full state after a soft reset.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_REGS = 16;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int ADDR_W   = 5;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ID1  = 2;
  localparam int IDX_ID2  = 3;
  localparam int IDX_ADV  = 4;
  localparam int IDX_LPA  = 5;

  localparam int CTRL_SRST_BIT = 15;
  localparam int STAT_LINK_BIT = 2;

  localparam logic [REG_W-1:0] CTRL_RST    = 16'h1000;
  localparam logic [REG_W-1:0] STAT_BASE   = 16'h7848;
  localparam logic [REG_W-1:0] ADV_RST     = 16'h01E1;
  localparam logic [REG_W-1:0] LPA_UP_OR   = 16'h01E1;
  localparam logic [REG_W-1:0] LPA_DN_AND  = 16'h01FF;
  localparam logic [REG_W-1:0] FOREIGN_RD  = 16'hFFFF;

  typedef struct packed {
    logic wr_ctrl;
    logic rd_stat;
    logic scan;
  } mgmt_cmd_t;

  function automatic logic [REG_W-1:0] base_rst(input int idx);
    case (idx)
      IDX_CTRL: return CTRL_RST;
      IDX_ADV:  return ADV_RST;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign rise_o = sync_o & ~prev_q;
  assign fall_o = ~sync_o & prev_q;
endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file import mgmt_phy_pkg::*; #(
  parameter logic [REG_W-1:0] ID_HI = 16'h2000,
  parameter logic [REG_W-1:0] ID_LO = 16'h5C90
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              link_i,
  input  logic              link_rise_i,
  input  logic              link_fall_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  logic [REG_W-1:0] regs [NUM_REGS];
  logic             soft_rst;

  assign soft_rst = wr_en_i && (wr_addr_i == ADDR_W'(IDX_CTRL)) && wr_data_i[CTRL_SRST_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_STAT) begin : g_stat
      logic [REG_W-1:0] stat_w;
      always_comb begin
        stat_w = STAT_BASE;
        stat_w[STAT_LINK_BIT] = link_i;
      end
      assign regs[i] = stat_w;
    end else if (i == IDX_ID1) begin : g_id1
      assign regs[i] = ID_HI;
    end else if (i == IDX_ID2) begin : g_id2
      assign regs[i] = ID_LO;
    end else begin : g_rw
      logic [REG_W-1:0] q, d;
      logic             hit;
      assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));
      always_comb begin
        d = q;
        if (hit) d = wr_data_i;
        if (i == IDX_LPA) begin
          if (link_rise_i) d = d | LPA_UP_OR;
          if (link_fall_i) d = d & LPA_DN_AND;
        end
        if (soft_rst) begin
          d = base_rst(i);
          if (i == IDX_LPA && link_i) d = LPA_UP_OR;
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= base_rst(i);
        else         q <= d;
      end
      assign regs[i] = q;
    end
  end

  assign rd_data_o = (rd_addr_i < ADDR_W'(NUM_REGS)) ? regs[rd_addr_i[REG_AW-1:0]] : '0;

  // R5
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> regs[IDX_CTRL] == CTRL_RST);

  // R10
  lpa_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rise_i |=> (regs[IDX_LPA] & LPA_UP_OR) == LPA_UP_OR);

  // R4
  adv_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(IDX_ADV)) |=> regs[IDX_ADV] == $past(wr_data_i));
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs import mgmt_phy_pkg::*; #(
  parameter int               PHY_ADDR    = 1,
  parameter logic [REG_W-1:0] ID_HI       = 16'h2000,
  parameter logic [REG_W-1:0] ID_LO       = 16'h5C90,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              data_wr_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              link_up_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              link_fail_o
);
  mgmt_cmd_t        cmd;
  logic             phy_hit, wr_en, rd_req;
  logic             link_s, link_rise, link_fall;
  logic [REG_W-1:0] rf_rdata, rdata_q;
  logic             scan_q, fail_q;

  assign cmd     = mgmt_cmd_t'(cmd_i);
  assign phy_hit = (phy_addr_i == ADDR_W'(PHY_ADDR));
  assign wr_en   = phy_hit && (data_wr_i || (cmd_valid_i && cmd.wr_ctrl));
  assign rd_req  = cmd_valid_i && cmd.rd_stat;

  link_sync #(.STAGES(SYNC_STAGES)) i_link_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (link_up_i),
    .sync_o  (link_s),
    .rise_o  (link_rise),
    .fall_o  (link_fall)
  );

  phy_reg_file #(.ID_HI(ID_HI), .ID_LO(ID_LO)) i_phy_reg_file (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (reg_addr_i),
    .wr_data_i   (wdata_i),
    .link_i      (link_s),
    .link_rise_i (link_rise),
    .link_fall_i (link_fall),
    .rd_addr_i   (reg_addr_i),
    .rd_data_o   (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      scan_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      if (rd_req) rdata_q <= phy_hit ? rf_rdata : FOREIGN_RD;
      if (cmd_valid_i) scan_q <= cmd.scan;
      if (rd_req || scan_q) fail_q <= ~link_s;
    end
  end

  assign rdata_o     = rdata_q;
  assign link_fail_o = fail_q;

  // R6
  foreign_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !phy_hit) |=> rdata_o == FOREIGN_RD);

  // R4
  oob_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && phy_hit && reg_addr_i >= ADDR_W'(NUM_REGS)) |=> rdata_o == '0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(rdata_o));

  // R9
  scan_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_q |=> link_fail_o == !$past(link_s));
endmodule

// File: tb/test_mgmt_phy_regs.sv
module test_mgmt_phy_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr = '0, reg_addr = '0;
  logic [15:0] wdata = '0;
  logic        data_wr = 1'b0, cmd_valid = 1'b0, link_up = 1'b0;
  logic [2:0]  cmd = '0;
  logic [15:0] rdata;
  logic        link_fail;

  int          n_chk = 0, n_fail = 0;
  logic [15:0] model [16];
  logic        link_m = 1'b0;

  always #2 clk = ~clk;

  mgmt_phy_regs i_mgmt_phy_regs (
    .clk_i(clk), .rst_ni(rst_n), .phy_addr_i(phy_addr), .reg_addr_i(reg_addr),
    .wdata_i(wdata), .data_wr_i(data_wr), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .link_up_i(link_up), .rdata_o(rdata), .link_fail_o(link_fail)
  );

  task automatic check(input string tag, input int idx, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s idx %0d: got %h expected %h", tag, idx, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = 16'h0000;
    model[0] = 16'h1000;
    model[4] = 16'h01E1;
    model[5] = link_m ? 16'h01E1 : 16'h0000;
  endtask

  function automatic logic [15:0] expect_rd(input int p, input int a);
    if (p != 1) return 16'hFFFF;
    if (a >= 16) return 16'h0000;
    if (a == 1) return 16'h7848 | (link_m ? 16'h0004 : 16'h0000);
    if (a == 2) return 16'h2000;
    if (a == 3) return 16'h5C90;
    return model[a];
  endfunction

  task automatic issue(input int p, input int a, input logic [2:0] c, input logic [15:0] d, input logic dw);
    @(negedge clk);
    phy_addr = 5'(p); reg_addr = 5'(a); wdata = d;
    cmd = c; cmd_valid = !dw; data_wr = dw;
    @(negedge clk);
    cmd_valid = 1'b0; data_wr = 1'b0; cmd = '0;
  endtask

  task automatic read_chk(input string tag, input int p, input int a);
    issue(p, a, 3'b010, 16'h0, 1'b0);
    check(tag, a, rdata, expect_rd(p, a));
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    repeat (6) @(negedge clk);
    if (v && !link_m) model[5] = model[5] | 16'h01E1;
    if (!v && link_m) model[5] = model[5] & 16'h01FF;
    link_m = v;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of outputs
    check("R1 rdata", 0, rdata, 16'h0);
    check("R1 link_fail", 0, 16'(link_fail), 16'h0);
    for (int a = 0; a < 32; a++) read_chk("R1 reset value", 1, a);
    check("R8 link_fail after read, link down", 0, 16'(link_fail), 16'h1);

    // R10 partner bits and R2 status bit on link up
    set_link(1'b1);
    read_chk("R2 status link up", 1, 1);
    read_chk("R10 partner on rise", 1, 5);
    check("R8 link_fail after read, link up", 0, 16'(link_fail), 16'h0);

    // R4 R2 R3 R7 write sweep over every index
    for (int a = 0; a < 32; a++) begin
      logic [15:0] v;
      v = (16'(a) * 16'h1111 ^ 16'h0A5A) & 16'h7FFF;
      issue(1, a, 3'b100, v, 1'b0);
      if (a < 16 && a != 1 && a != 2 && a != 3) model[a] = v;
    end
    for (int a = 0; a < 32; a++) read_chk("R4 sweep readback", 1, a);

    // R7 data-path write trigger, R3 identity ignores it
    issue(1, 9, 3'b000, 16'hBEEF, 1'b1);
    model[9] = 16'hBEEF;
    read_chk("R7 data_wr store", 1, 9);
    issue(1, 2, 3'b000, 16'h1234, 1'b1);
    read_chk("R3 id ignores data_wr", 1, 2);
    issue(1, 1, 3'b000, 16'h0000, 1'b1);
    read_chk("R2 status ignores data_wr", 1, 1);

    // R8 read+write in one command returns the old word
    issue(1, 7, 3'b110, 16'h5555, 1'b0);
    check("R8 read before write", 7, rdata, model[7]);
    model[7] = 16'h5555;
    read_chk("R8 write took effect", 1, 7);

    // R6 foreign PHY addresses
    for (int p = 0; p < 32; p++) begin
      if (p == 1) continue;
      issue(p, 6, 3'b100, 16'(p), 1'b0);
      issue(p, 8, 3'b000, 16'(p), 1'b1);
      read_chk("R6 foreign read", p, 6);
    end
    read_chk("R6 foreign write ignored", 1, 6);
    read_chk("R6 foreign data_wr ignored", 1, 8);

    // R10 partner register on fall then rise
    issue(1, 5, 3'b100, 16'h1200, 1'b0);
    model[5] = 16'h1200;
    set_link(1'b0);
    read_chk("R10 partner after fall", 1, 5);
    read_chk("R2 status link down", 1, 1);
    set_link(1'b1);
    read_chk("R10 partner after rise", 1, 5);

    // R9 / R11 scan mode and synchroniser latency
    issue(1, 0, 3'b001, 16'h0, 1'b0);
    @(negedge clk);
    check("R9 scan link up", 0, 16'(link_fail), 16'h0);
    link_up = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 not yet after two edges", 0, 16'(link_fail), 16'h0);
    @(negedge clk);
    check("R11 R9 visible on third edge", 0, 16'(link_fail), 16'h1);
    repeat (4) @(negedge clk);
    model[5] = model[5] & 16'h01FF;
    link_m = 1'b0;
    issue(1, 0, 3'b000, 16'h0, 1'b0);
    set_link(1'b1);
    check("R9 scan off holds link_fail", 0, 16'(link_fail), 16'h1);
    read_chk("R10 partner after scan test", 1, 5);
    check("R8 read refreshes link_fail", 0, 16'(link_fail), 16'h0);

    // R5 soft reset with link up
    issue(1, 0, 3'b100, 16'h8123, 1'b0);
    model_reset();
    for (int a = 0; a < 16; a++) read_chk("R5 soft reset value", 1, a);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule